// File: doc/BRIEF.md
# Periodic Timeout Interrupt Flag Unit

This block is a small real-time timer. It counts pulses of a prescaled clock-enable input and produces a timeout event every half second. The event sets two flags. The first is an interrupt request that goes to an interrupt controller, together with a fixed vector address. The second is a sticky status bit that software can see. The request clears when the controller acknowledges it. The status bit survives servicing and clears only when software writes it.

Software reaches the unit through one 8-bit control and status register. The register holds a run-enable bit and the sticky status bit, and every other bit position reads as zero. The parameter `TICKS_PER_HALF_SEC` gives the number of enable pulses in half a second. The oscillator, interrupt priority and the processor are outside this block.

Top module: `hbt_tick_irq`

## Requirements
- R1: After a synchronous reset, the run-enable bit, the status bit, the interrupt request and the divider are all 0, so `reg_rd_data` reads 8'h00 and `irq_req` is 0.
- R2: The register layout is fixed. `reg_rd_data[7]` is the sticky status bit and `reg_rd_data[5]` is the run-enable bit. Bits 6 and 4..0 always read 0, whatever was written. A write with `reg_wr`=1 loads bit 7 and bit 5 from `reg_wdata`, and the result is visible after that clock edge.
- R3: While enabled, the timeout fires on the clock edge that samples the `TICKS_PER_HALF_SEC`-th `tick_en` pulse since the divider was last zero. From the next cycle, `irq_req`=1 and `reg_rd_data[7]`=1. The divider then restarts from zero.
- R4: While the enable bit is 0, `tick_en` pulses are ignored and the divider is held at zero. After re-enabling, a full `TICKS_PER_HALF_SEC` pulses are needed for the next timeout.
- R5: `irq_ack`=1 clears `irq_req` on the next cycle and leaves the status bit unchanged.
- R6: A register write with bit 7 equal to 0 clears the status bit and leaves `irq_req` unchanged.
- R7: If a timeout and a software write of 0 to bit 7 happen on the same edge, the status bit ends up 1.
- R8: If a timeout and `irq_ack` happen on the same edge, `irq_req` ends up 1.
- R9: `irq_vector` always presents 8'h14.
- R10: The divider counts `tick_en` pulses, not clock cycles. Clock cycles with `tick_en`=0 do not advance it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Prescaled clock-enable pulse, one clock wide |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rd_data | output | 8 | Register read value |
| irq_ack | input | 1 | Interrupt acknowledge from the controller |
| irq_req | output | 1 | Interrupt request flag |
| irq_vector | output | 8 | Vector address for this source |

## Verification
A register write shows in `reg_rd_data` right after the edge that takes it, because the read path adds no register. A timeout shows in both `irq_req` and status bit 7 one edge after the clock that samples the final tick. An acknowledge clears the request one edge after it is sampled. The bench drives each stimulus for exactly one edge and queues the values expected after that edge. A monitor then compares them at the following falling edge, so each result is checked in the cycle the requirement places it and never earlier.

// File: rtl/hbt_pkg.sv
package hbt_pkg;

    // Width of the software register.
    localparam int CTRL_W = 8;

    // Bit positions in the register. Software decodes these positions.
    localparam int STATUS_BIT = 7;
    localparam int ENABLE_BIT = 5;

    // Vector address presented for this interrupt source.
    localparam logic [7:0] IRQ_VEC = 8'h14;

    typedef struct packed {
        logic status;
        logic enable;
    } ctrl_t;

    // Builds the read value: only the two live bits are non-zero.
    function automatic logic [CTRL_W-1:0] ctrl_pack(ctrl_t c);
        logic [CTRL_W-1:0] v;
        v = '0;
        v[STATUS_BIT] = c.status;
        v[ENABLE_BIT] = c.enable;
        return v;
    endfunction

endpackage

// File: rtl/hbt_divider.sv
module hbt_divider #(
    parameter int TICKS = 16384
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic tick_i,
    output logic hit_o
);
    localparam int CW = (TICKS < 2) ? 1 : $clog2(TICKS);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;

    // The hit pulse comes out on the tick that ends a half second.
    assign hit_o = run_i && tick_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (cnt_q == LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/hbt_ctrl_reg.sv
module hbt_ctrl_reg
    import hbt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_i,
    input  logic  wr_status_i,
    input  logic  wr_enable_i,
    input  logic  hit_i,
    output ctrl_t ctrl_o
);
    ctrl_t ctrl_q, ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_i) begin
            ctrl_d.status = wr_status_i;
            ctrl_d.enable = wr_enable_i;
        end
        // A hardware timeout overrides a software clear on the same edge.
        if (hit_i) ctrl_d.status = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end

    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/hbt_irq_flag.sv
module hbt_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic ack_i,
    output logic req_o
);
    logic req_q;

    always_ff @(posedge clk) begin
        if (rst)        req_q <= 1'b0;
        else if (set_i) req_q <= 1'b1;   // a new event wins over the acknowledge
        else if (ack_i) req_q <= 1'b0;
    end

    assign req_o = req_q;
endmodule

// File: rtl/hbt_tick_irq.sv
module hbt_tick_irq
    import hbt_pkg::*;
#(
    parameter int TICKS_PER_HALF_SEC = 16384
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              reg_wr,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rd_data,
    input  logic              irq_ack,
    output logic              irq_req,
    output logic [7:0]        irq_vector
);
    ctrl_t ctrl_w;
    logic  hit_w;
    logic  wdata_unused;

    // The bits that have no function are dropped here.
    assign wdata_unused = &{1'b0, reg_wdata[6], reg_wdata[4:0]};

    hbt_divider #(.TICKS(TICKS_PER_HALF_SEC)) u_div (
        .clk    (clk),
        .rst    (rst),
        .run_i  (ctrl_w.enable),
        .tick_i (tick_en),
        .hit_o  (hit_w)
    );

    hbt_ctrl_reg u_reg (
        .clk         (clk),
        .rst         (rst),
        .wr_i        (reg_wr),
        .wr_status_i (reg_wdata[STATUS_BIT]),
        .wr_enable_i (reg_wdata[ENABLE_BIT]),
        .hit_i       (hit_w),
        .ctrl_o      (ctrl_w)
    );

    hbt_irq_flag u_irq (
        .clk   (clk),
        .rst   (rst),
        .set_i (hit_w),
        .ack_i (irq_ack),
        .req_o (irq_req)
    );

    assign reg_rd_data = ctrl_pack(ctrl_w);
    assign irq_vector  = IRQ_VEC;
endmodule

// File: rtl/hbt_tick_irq_chk.sv
module hbt_tick_irq_chk (
    input logic       clk,
    input logic       rst,
    input logic       hit,
    input logic       irq_ack,
    input logic       irq_req,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rd_data
);
    p_timeout_sets_r3: assert property (@(posedge clk) disable iff (rst)
        hit |=> (irq_req && reg_rd_data[7]));

    p_rise_needs_timeout_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) |-> $past(hit));

    p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !reg_rd_data[5] |-> !hit);

    p_ack_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !hit) |=> !irq_req);

    p_ack_keeps_status_r5: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !reg_wr && !hit) |=> $stable(reg_rd_data[7]));

    p_sw_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_wdata[7] && !hit) |=> !reg_rd_data[7]);

    p_timeout_beats_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (hit && reg_wr && !reg_wdata[7]) |=> reg_rd_data[7]);

    p_timeout_beats_ack_r8: assert property (@(posedge clk) disable iff (rst)
        (hit && irq_ack) |=> irq_req);
endmodule

bind hbt_tick_irq hbt_tick_irq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .hit         (hit_w),
    .irq_ack     (irq_ack),
    .irq_req     (irq_req),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rd_data (reg_rd_data)
);

// File: tb/sim_hbt_tick_irq.sv
`timescale 1ns/1ps
module sim_hbt_tick_irq;
    localparam int N = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic       irq_ack = 1'b0;
    logic [7:0] reg_rd_data;
    logic       irq_req;
    logic [7:0] irq_vector;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        string      tag;
        logic       irq;
        logic [7:0] rd;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;

    hbt_tick_irq #(.TICKS_PER_HALF_SEC(N)) u0 (
        .clk(clk), .rst(rst), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd_data(reg_rd_data), .irq_ack(irq_ack),
        .irq_req(irq_req), .irq_vector(irq_vector)
    );

    // Driver: hold the inputs for one rising edge, then release them.
    task automatic cyc(input logic t, input logic w, input logic [7:0] d, input logic a);
        tick_en = t; reg_wr = w; reg_wdata = d; irq_ack = a;
        @(posedge clk); #1;
        tick_en = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00; irq_ack = 1'b0;
    endtask

    task automatic expect_now(input string tag, input logic irq, input logic [7:0] rd);
        exp_t e;
        e.tag = tag; e.irq = irq; e.rd = rd;
        q.push_back(e);
    endtask

    task automatic ticks(input int n, input string tag, input logic irq, input logic [7:0] rd);
        for (int i = 0; i < n; i++) begin
            cyc(1'b1, 1'b0, 8'h00, 1'b0);
            expect_now(tag, irq, rd);
        end
    endtask

    // Monitor: compare the queued values at the falling edge.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (irq_req !== e.irq) begin
                failures++;
                $display("FAIL %s irq_req actual=%0b expected=%0b", e.tag, irq_req, e.irq);
            end
            checks++;
            if (reg_rd_data !== e.rd) begin
                failures++;
                $display("FAIL %s reg_rd_data actual=%02h expected=%02h", e.tag, reg_rd_data, e.rd);
            end
            checks++;
            if (irq_vector !== 8'h14) begin
                failures++;
                $display("FAIL R9 irq_vector actual=%02h expected=14", irq_vector);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        expect_now("R1", 1'b0, 8'h00);
        cyc(0, 0, 8'h00, 0);
        expect_now("R1", 1'b0, 8'h00);

        // R2: only bits 7 and 5 are stored.
        cyc(0, 1, 8'hFF, 0);  expect_now("R2", 1'b0, 8'hA0);
        cyc(0, 1, 8'h5F, 0);  expect_now("R2", 1'b0, 8'h00);

        // R3 and R10: ticks separated by idle cycles.
        cyc(0, 1, 8'h20, 0);  expect_now("R2", 1'b0, 8'h20);
        for (int i = 0; i < N - 1; i++) begin
            cyc(1, 0, 8'h00, 0); expect_now("R10", 1'b0, 8'h20);
            cyc(0, 0, 8'h00, 0); expect_now("R10", 1'b0, 8'h20);
            cyc(0, 0, 8'h00, 0); expect_now("R10", 1'b0, 8'h20);
        end
        cyc(1, 0, 8'h00, 0);  expect_now("R3", 1'b1, 8'hA0);

        // R5: the acknowledge clears the request, and the status stays.
        cyc(0, 0, 8'h00, 1);  expect_now("R5", 1'b0, 8'hA0);

        // R3: the divider restarted, and a second half second fires again.
        ticks(N - 1, "R3", 1'b0, 8'hA0);
        ticks(1, "R3", 1'b1, 8'hA0);

        // R6: the software clear leaves the request alone.
        cyc(0, 1, 8'h20, 0);  expect_now("R6", 1'b1, 8'h20);
        cyc(0, 0, 8'h00, 1);  expect_now("R5", 1'b0, 8'h20);

        // R4: while disabled the divider is held at zero.
        ticks(3, "R4", 1'b0, 8'h20);
        cyc(0, 1, 8'h00, 0);  expect_now("R4", 1'b0, 8'h00);
        ticks(2 * N, "R4", 1'b0, 8'h00);
        cyc(0, 1, 8'h20, 0);  expect_now("R4", 1'b0, 8'h20);
        ticks(N - 1, "R4", 1'b0, 8'h20);
        ticks(1, "R4", 1'b1, 8'hA0);
        cyc(0, 0, 8'h00, 1);  expect_now("R5", 1'b0, 8'hA0);

        // R7: a timeout on the same edge as a software clear.
        cyc(0, 1, 8'h20, 0);  expect_now("R6", 1'b0, 8'h20);
        ticks(N - 1, "R7", 1'b0, 8'h20);
        cyc(1, 1, 8'h20, 0);  expect_now("R7", 1'b1, 8'hA0);

        // R8: a timeout on the same edge as an acknowledge.
        ticks(N - 1, "R8", 1'b1, 8'hA0);
        cyc(1, 0, 8'h00, 1);  expect_now("R8", 1'b1, 8'hA0);
        cyc(0, 0, 8'h00, 1);  expect_now("R5", 1'b0, 8'hA0);

        // R1: a reset in the middle of operation clears everything.
        rst = 1'b1;
        cyc(1, 0, 8'h00, 0);  expect_now("R1", 1'b0, 8'h00);
        rst = 1'b0;
        cyc(0, 0, 8'h00, 0);  expect_now("R1", 1'b0, 8'h00);

        @(posedge clk); @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired before the scenario ended");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule